// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address that a synchronous memory uses in each cycle of a four-word burst. A command cycle either starts a burst or moves it forward, chosen by a load/advance line. On a start, the block captures the external address and whether the access is a read or a write. On each advance cycle, a small internal counter steps. The counter is combined with the two low bits of the captured address to form the word offset. The upper address bits never move.

A mode input picks how the offset is formed. Linear order adds the count to the start offset. Interleaved order XORs the count into the start offset. A load request made while the device is not selected ends the current burst. After that, advance requests do nothing until a valid load arrives. An active-low clock enable freezes all internal state.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `cur_addr` is 0, `burst_act` is 0 and `burst_wr` is 0.
- R2: Suppose a cycle has `cen_n`=0, `adv_ld`=0 and `sel`=1. After that edge, `cur_addr` equals `ext_addr` and `burst_act` is 1. `burst_wr` then equals the `wr_req` value of that cycle.
- R3: With `mode`=0, after k advance cycles (`cen_n`=0, `adv_ld`=1) of an active burst, bits [1:0] of `cur_addr` equal (start + k) mod 4.
- R4: With `mode`=1, bits [1:0] of `cur_addr` equal start XOR (k mod 4). `mode` acts on `cur_addr` in the same cycle, without waiting for a clock edge.
- R5: Four advance cycles after a load bring `cur_addr` back to the loaded address.
- R6: Bits above [1:0] of `cur_addr` do not change across advance cycles.
- R7: `burst_wr` keeps its loaded value through every advance cycle.
- R8: Suppose a cycle has `cen_n`=0, `adv_ld`=0 and `sel`=0. After that edge, `burst_act` is 0 and `cur_addr` keeps its value. Later advance cycles leave `cur_addr` and `burst_act` unchanged until the next valid load.
- R9: While `cen_n`=1, `cur_addr`, `burst_act` and `burst_wr` hold their values whatever the other inputs do (with `mode` held).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cen_n | input | 1 | Clock enable, active low; 1 freezes state |
| sel | input | 1 | Combined chip-select status, 1 = all enables active |
| adv_ld | input | 1 | 0 = load a new burst, 1 = advance the current burst |
| mode | input | 1 | 0 = linear order, 1 = interleaved order |
| wr_req | input | 1 | Access type captured at load, 1 = write |
| ext_addr | input | ADDR_W | External start address |
| cur_addr | output | ADDR_W | Address of the current burst word |
| burst_act | output | 1 | A burst is in progress |
| burst_wr | output | 1 | Captured access type of the current burst |

## Verification
The bench builds the block with a 12-bit address, a 2-bit counter and the interleaved variant enabled. A 12-bit address is narrow enough that random starts hit every low-bit offset many times. It is also wide enough for upper-bit corruption to show up. With the interleaved variant present, `mode` can be toggled in any cycle, so both orderings are exercised from the same counter state, including the wrap back to the start word. Random runs of deselected loads and frozen cycles reach the stopped-burst and hold paths in every counter phase.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
   typedef enum logic [1:0] {
      SQ_HOLD = 2'd0,
      SQ_LOAD = 2'd1,
      SQ_STOP = 2'd2,
      SQ_STEP = 2'd3
   } seq_op_e;
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
   import bseq_pkg::*;
(
   input  logic    cen_n,
   input  logic    sel,
   input  logic    adv_ld,
   input  logic    active,
   output seq_op_e op
);
   always_comb begin
      op = SQ_HOLD;
      if (!cen_n) begin
         if (!adv_ld) op = sel ? SQ_LOAD : SQ_STOP;
         else if (active) op = SQ_STEP;
      end
   end
endmodule

// File: rtl/bseq_count.sv
module bseq_count
   import bseq_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_op_e          op,
   output logic [CNT_W-1:0] cnt
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else begin
         case (op)
            SQ_LOAD: cnt_q <= '0;
            SQ_STEP: cnt_q <= cnt_q + CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/bseq_order.sv
module bseq_order #(
   parameter int CNT_W          = 2,
   parameter bit HAS_INTERLEAVE = 1'b1
) (
   input  logic [CNT_W-1:0] start,
   input  logic [CNT_W-1:0] cnt,
   input  logic             mode,
   output logic [CNT_W-1:0] offs
);
   logic [CNT_W-1:0] lin_offs;
   assign lin_offs = start + cnt;

   generate
      if (HAS_INTERLEAVE) begin : g_both
         assign offs = mode ? (start ^ cnt) : lin_offs;
      end else begin : g_lin
         logic unused_mode;
         assign unused_mode = mode;
         assign offs = lin_offs;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bseq_pkg::*;
#(
   parameter int ADDR_W         = 20,
   parameter int CNT_W          = 2,
   parameter bit HAS_INTERLEAVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cen_n,
   input  logic              sel,
   input  logic              adv_ld,
   input  logic              mode,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              burst_act,
   output logic              burst_wr
);
   localparam int HI_W = ADDR_W - CNT_W;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (ADDR_W <= CNT_W) begin : g_bad_addr
         $error("ADDR_W must exceed CNT_W");
      end
   endgenerate

   seq_op_e             op;
   logic [ADDR_W-1:0]   base_q;
   logic                act_q;
   logic                wr_q;
   logic [CNT_W-1:0]    cnt;
   logic [CNT_W-1:0]    offs;

   bseq_ctrl u_ctrl (
      .cen_n (cen_n),
      .sel   (sel),
      .adv_ld(adv_ld),
      .active(act_q),
      .op    (op)
   );

   bseq_count #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .op   (op),
      .cnt  (cnt)
   );

   bseq_order #(.CNT_W(CNT_W), .HAS_INTERLEAVE(HAS_INTERLEAVE)) u_ord (
      .start(base_q[CNT_W-1:0]),
      .cnt  (cnt),
      .mode (mode),
      .offs (offs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         act_q  <= 1'b0;
         wr_q   <= 1'b0;
      end else begin
         case (op)
            SQ_LOAD: begin
               base_q <= ext_addr;
               act_q  <= 1'b1;
               wr_q   <= wr_req;
            end
            SQ_STOP: act_q <= 1'b0;
            default: ;
         endcase
      end
   end

   assign cur_addr  = {base_q[ADDR_W-1:CNT_W], offs};
   assign burst_act = act_q;
   assign burst_wr  = wr_q;

   // R2
   load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && !adv_ld && sel) |=> (burst_act && burst_wr == $past(wr_req)
         && cur_addr[ADDR_W-1:CNT_W] == $past(ext_addr[ADDR_W-1:CNT_W])));
   // R6
   upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && adv_ld) |=> $stable(cur_addr[ADDR_W-1:CNT_W]));
   // R7
   type_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && adv_ld) |=> $stable(burst_wr));
   // R8
   stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && !adv_ld && !sel) |=> !burst_act);
   // R8
   idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_ld && !burst_act) |=> !burst_act);
   // R9
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cen_n |=> ($stable(burst_act) && $stable(burst_wr)
         && $stable(cur_addr[ADDR_W-1:CNT_W])));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 12;
   localparam int WATCHDOG = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cen_n = 1'b1, sel = 1'b0, adv_ld = 1'b1, mode = 1'b0, wr_req = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic [AW-1:0] cur_addr;
   logic          burst_act, burst_wr;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   // bench model state
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_k = '0;
   logic          m_act = 1'b0, m_wr = 1'b0;

   burst_addr_seq #(.ADDR_W(AW), .CNT_W(2), .HAS_INTERLEAVE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sel(sel), .adv_ld(adv_ld),
      .mode(mode), .wr_req(wr_req), .ext_addr(ext_addr),
      .cur_addr(cur_addr), .burst_act(burst_act), .burst_wr(burst_wr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] k, logic md);
      logic [1:0] lo;
      lo = md ? (b[1:0] ^ k) : (b[1:0] + k);
      return {b[AW-1:2], lo};
   endfunction

   task automatic chk(string tag, logic [AW-1:0] ea, logic eact, logic ewr);
      tests++;
      if (cur_addr !== ea || burst_act !== eact || burst_wr !== ewr) begin
         fails++;
         $display("FAIL %s: addr=%h act=%b wr=%b expected addr=%h act=%b wr=%b",
                  tag, cur_addr, burst_act, burst_wr, ea, eact, ewr);
      end
   endtask

   // drive one cycle (called just after a falling edge), then check at next falling edge
   task automatic cyc(logic c, logic s, logic a, logic md, logic w, logic [AW-1:0] ad, string tag);
      cen_n = c; sel = s; adv_ld = a; mode = md; wr_req = w; ext_addr = ad;
      @(posedge clk);
      if (!c) begin
         if (!a && s) begin m_base = ad; m_k = 2'd0; m_act = 1'b1; m_wr = w; end
         else if (!a) m_act = 1'b0;
         else if (m_act) m_k = m_k + 2'd1;
      end
      @(negedge clk);
      chk(tag, exp_addr(m_base, m_k, md), m_act, m_wr);
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", '0, 1'b0, 1'b0);

      // R2, R3, R5, R6, R7: linear burst from offset 2
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 12'hA5E, "R2");
      tests++; if (cur_addr !== 12'hA5E) begin fails++; $display("FAIL R2: addr=%h expected=%h", cur_addr, 12'hA5E); end
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R3");
      tests++; if (cur_addr !== 12'hA5F) begin fails++; $display("FAIL R3: addr=%h expected=%h", cur_addr, 12'hA5F); end
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'hFFF, "R6");
      tests++; if (cur_addr !== 12'hA5C) begin fails++; $display("FAIL R6: addr=%h expected=%h", cur_addr, 12'hA5C); end
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'h123, "R7");
      tests++; if (burst_wr !== 1'b1) begin fails++; $display("FAIL R7: wr=%b expected=1", burst_wr); end
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R5");
      tests++; if (cur_addr !== 12'hA5E) begin fails++; $display("FAIL R5: addr=%h expected=%h", cur_addr, 12'hA5E); end

      // R4: interleaved burst from offset 1
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h3C5, "R2");
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 12'h000, "R4");
      tests++; if (cur_addr !== 12'h3C4) begin fails++; $display("FAIL R4: addr=%h expected=%h", cur_addr, 12'h3C4); end
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 12'h000, "R4");
      tests++; if (cur_addr !== 12'h3C7) begin fails++; $display("FAIL R4: addr=%h expected=%h", cur_addr, 12'h3C7); end
      // same state, linear view: start 1 + 2 = 3 as well; step once more and compare both
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 12'h000, "R4");
      tests++; if (cur_addr !== 12'h3C6) begin fails++; $display("FAIL R4: addr=%h expected=%h", cur_addr, 12'h3C6); end
      mode = 1'b0; #1;
      tests++; if (cur_addr !== 12'h3C4) begin fails++; $display("FAIL R3: addr=%h expected=%h", cur_addr, 12'h3C4); end
      mode = 1'b1;

      // R8: deselected load stops the burst; advances ignored
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h777, "R8");
      tests++; if (burst_act !== 1'b0 || cur_addr !== 12'h3C6) begin fails++; $display("FAIL R8: act=%b addr=%h expected act=0 addr=%h", burst_act, cur_addr, 12'h3C6); end
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R8");
      tests++; if (cur_addr !== 12'h3C6) begin fails++; $display("FAIL R8: addr=%h expected=%h", cur_addr, 12'h3C6); end

      // R9: clock enable high freezes everything
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 12'h801, "R2");
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'h456, "R9");
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'h456, "R9");
      tests++; if (cur_addr !== 12'h801 || burst_act !== 1'b1) begin fails++; $display("FAIL R9: addr=%h act=%b expected addr=%h act=1", cur_addr, burst_act, 12'h801); end

      // random mix checked against the model
      for (int i = 0; i < 3000; i++) begin
         logic c, s, a, md, w;
         string tg;
         c  = ($urandom % 10) == 0;
         a  = ($urandom % 10) >= 3;
         s  = ($urandom % 4) != 0;
         md = $urandom % 2;
         w  = $urandom % 2;
         if (c) tg = "R9";
         else if (!a && s) tg = "R2";
         else if (!a || !m_act) tg = "R8";
         else if (md) tg = "R4";
         else tg = "R3";
         cyc(c, s, a, md, w, AW'($urandom), tg);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule